// File: doc/BRIEF.md
# Burst Read Wait and Output Sequencer

This block paces the data phase of a synchronous burst read. A one-clock start strobe loads a starting word address. From the next clock the block presents a sequence of word addresses to the array side, drives the returned word onto the data bus with a valid strobe, and drives a WAIT pin that tells the host whether the word on the bus can be taken. The initial access latency is handled elsewhere, so the first data cycle of a burst follows the start strobe directly.

The host-visible timing comes from four configuration inputs, which are captured when a burst starts. One sets the active level of WAIT. One sets the length of a data cycle to one or two clocks. One moves WAIT one data cycle ahead of the stall. One selects the burst ordering; only sequential ordering exists. The array side reports a coming stall on the not-ready input. The block samples that input on the last clock of each data cycle, and it applies to the data cycle two ahead. This one-data-cycle lookahead is what makes early WAIT possible.

A burst ends after `BURST_LEN` valid words. A new start strobe restarts the burst at any time.

Top module: `burst_wait_seq`

## Requirements
- R1: When a burst is active, WAIT is high for an active-high setting (`cfg_wait_pol_i`=1) and low for an active-low setting (0). The setting is the value captured at the start of the burst.
- R2: With `cfg_hold2_i`=0 a data cycle lasts one clock. With `cfg_hold2_i`=1 it lasts two clocks. `dvalid_o` stays high for the whole of a valid data cycle.
- R3: With `cfg_early_i`=0, WAIT is active exactly in wait data cycles. With `cfg_early_i`=1, WAIT is active in the data cycle just before each wait data cycle.
- R4: Outside a burst, WAIT sits at the inactive level selected by the live `cfg_wait_pol_i` input, and `dvalid_o` is 0.
- R5: Word addresses start at `start_addr_i` and rise by one after each valid data cycle. They wrap modulo 2^`ADDR_W`, whatever the value of `cfg_seq_i`.
- R6: A high `stall_i` on the last clock of a data cycle makes the data cycle two ahead a wait cycle. In a wait cycle, `dvalid_o` is 0, the address does not change, and `data_o` keeps the last valid word.
- R7: A start strobe during a burst abandons that burst. On the next clock the address is the new `start_addr_i`, and no stall is pending.
- R8: Configuration inputs that change during a burst have no effect until the next start strobe.
- R9: A start strobe with `cfg_seq_i`=0 sets `unsup_o`. The flag stays set until reset.
- R10: A burst ends after exactly `BURST_LEN` valid data cycles, and `dvalid_o` then stays 0.
- R11: After reset, the address is 0, `dvalid_o` and `unsup_o` are 0, and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst start strobe, one clock |
| start_addr_i | input | ADDR_W | First word address of the burst |
| cfg_wait_pol_i | input | 1 | WAIT level: 1 active high, 0 active low |
| cfg_hold2_i | input | 1 | Data cycle length: 1 two clocks, 0 one clock |
| cfg_early_i | input | 1 | 1 moves WAIT one data cycle ahead of the stall |
| cfg_seq_i | input | 1 | Ordering: 1 sequential, 0 unsupported (still sequential) |
| stall_i | input | 1 | Not-ready indication for the data cycle two ahead |
| arr_data_i | input | DATA_W | Array word for the address on `addr_o`, same clock |
| addr_o | output | ADDR_W | Current word address |
| dvalid_o | output | 1 | The word on `data_o` is valid this clock |
| data_o | output | DATA_W | Read data |
| wait_o | output | 1 | WAIT pin, polarity applied |
| unsup_o | output | 1 | Sticky flag for an unsupported ordering request |

## Verification
The assertions assume that `arr_data_i` is a combinational function of `addr_o`. They also assume that `stall_i` matters only on the last clock of a data cycle, and that the configuration pins may change freely between bursts. The bench drives every input just after the falling edge and models the array as a fixed function of the address. It toggles `stall_i` in a periodic pattern that lands on both data-cycle boundaries and mid-cycle clocks. It changes configuration pins in the middle of a burst, so the latched values are tested against the live ones.

// File: rtl/bws_pkg.sv
package bws_pkg;

  // Configuration captured when a burst starts
  typedef struct packed {
    logic pol;    // 1: WAIT active high
    logic hold2;  // 1: two clocks per data cycle
    logic early;  // 1: WAIT leads the stall by one data cycle
  } bws_cfg_t;

  // True on the last clock of a data cycle
  function automatic logic last_phase(input logic hold2, input logic ph);
    return hold2 ? ph : 1'b1;
  endfunction

  // Apply polarity to an active-high wait request
  function automatic logic wait_level(input logic pol, input logic req);
    return pol ? req : ~req;
  endfunction

endpackage

// File: rtl/bws_cfg_latch.sv
module bws_cfg_latch
  import bws_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     busy_i,
  input  bws_cfg_t cfg_i,
  input  logic     seq_i,
  output bws_cfg_t cfg_o,
  output logic     unsup_o
);
  bws_cfg_t cfg_q;
  logic     unsup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      unsup_q <= 1'b0;
    end else if (start_i) begin
      cfg_q <= cfg_i;
      if (!seq_i) unsup_q <= 1'b1;
    end
  end

  assign cfg_o   = cfg_q;
  assign unsup_o = unsup_q;

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && busy_i) |=> $stable(cfg_q));

  // R9
  unsup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_q |=> unsup_q);

endmodule

// File: rtl/bws_beat_timer.sv
module bws_beat_timer
  import bws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic busy_i,
  input  logic hold2_i,
  output logic bnd_o
);
  logic ph_q;
  logic bnd;

  assign bnd   = busy_i && !start_i && last_phase(hold2_i, ph_q);
  assign bnd_o = bnd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph_q <= 1'b0;
    else if (start_i) ph_q <= 1'b0;
    else if (busy_i)  ph_q <= bnd ? 1'b0 : ph_q + 1'b1;
  end

  // R2
  one_clock_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !hold2_i) |-> (ph_q == 1'b0));

  // R2
  two_clock_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && hold2_i && !start_i && !ph_q) |=> (ph_q || !busy_i || $past(start_i)));

endmodule

// File: rtl/bws_stall_pipe.sv
module bws_stall_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bnd_i,
  input  logic stall_i,
  output logic pend_o,
  output logic cur_o
);
  logic pend_q, cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cur_q  <= 1'b0;
    end else if (start_i) begin
      pend_q <= 1'b0;
      cur_q  <= 1'b0;
    end else if (bnd_i) begin
      cur_q  <= pend_q;
      pend_q <= stall_i;
    end
  end

  assign pend_o = pend_q;
  assign cur_o  = cur_q;

  // R6
  stall_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_i && !start_i) |=> (cur_q == $past(pend_q)));

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!cur_q && !pend_q));

endmodule

// File: rtl/bws_addr_ctr.sv
module bws_addr_ctr #(
  parameter int ADDR_W    = 8,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              bnd_i,
  input  logic              cur_wait_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o
);
  localparam int CW = $clog2(BURST_LEN + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [CW-1:0]     cnt_q;
  logic              busy_q;
  logic              word_done;

  assign word_done = bnd_i && !cur_wait_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      addr_q <= start_addr_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (word_done) begin
      addr_q <= addr_q + 1'b1;
      cnt_q  <= cnt_q + 1'b1;
      if (cnt_q == CW'(BURST_LEN - 1)) busy_q <= 1'b0;
    end
  end

  assign addr_o = addr_q;
  assign busy_o = busy_q;

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !word_done) |=> $stable(addr_q));

  // R7
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_q && addr_q == $past(start_addr_i)));

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CW'(BURST_LEN)));

endmodule

// File: rtl/burst_wait_seq.sv
module burst_wait_seq
  import bws_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              cfg_wait_pol_i,
  input  logic              cfg_hold2_i,
  input  logic              cfg_early_i,
  input  logic              cfg_seq_i,
  input  logic              stall_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dvalid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              wait_o,
  output logic              unsup_o
);
  bws_cfg_t cfg_in, cfg;
  logic busy, bnd, pend_wait, cur_wait, wait_req, pol_now, dvalid;
  logic [DATA_W-1:0] data_q;

  assign cfg_in = '{pol: cfg_wait_pol_i, hold2: cfg_hold2_i, early: cfg_early_i};

  bws_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy),
    .cfg_i(cfg_in), .seq_i(cfg_seq_i), .cfg_o(cfg), .unsup_o(unsup_o)
  );

  bws_beat_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy),
    .hold2_i(cfg.hold2), .bnd_o(bnd)
  );

  bws_stall_pipe u_stall (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .bnd_i(bnd),
    .stall_i(stall_i), .pend_o(pend_wait), .cur_o(cur_wait)
  );

  bws_addr_ctr #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_addr (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .bnd_i(bnd), .cur_wait_i(cur_wait), .addr_o(addr_o), .busy_o(busy)
  );

  assign dvalid   = busy && !cur_wait;
  assign wait_req = busy && (cfg.early ? pend_wait : cur_wait);
  assign pol_now  = busy ? cfg.pol : cfg_wait_pol_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (dvalid) data_q <= arr_data_i;
  end

  assign dvalid_o = dvalid;
  assign data_o   = dvalid ? arr_data_i : data_q;
  assign wait_o   = wait_level(pol_now, wait_req);

  // R3
  late_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg.early && dvalid_o) |-> (wait_o == !cfg.pol));

  // R4
  idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wait_o == !cfg_wait_pol_i && !dvalid_o));

  // R6
  stall_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid_o && !start_i) ##1 !dvalid_o |-> (data_o == $past(data_o)));

endmodule

// File: tb/burst_wait_seq_tb.sv
module burst_wait_seq_tb;
  localparam int AW = 8, DW = 16, LEN = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start_i, pol_i, hold_i, early_i, seq_i, stall_i;
  logic [AW-1:0] sa_i, addr_o;
  logic [DW-1:0] arr_data, data_o;
  logic dvalid_o, wait_o, unsup_o;

  assign arr_data = {addr_o, ~addr_o};

  burst_wait_seq #(.ADDR_W(AW), .DATA_W(DW), .BURST_LEN(LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(sa_i),
    .cfg_wait_pol_i(pol_i), .cfg_hold2_i(hold_i), .cfg_early_i(early_i),
    .cfg_seq_i(seq_i), .stall_i(stall_i), .arr_data_i(arr_data),
    .addr_o(addr_o), .dvalid_o(dvalid_o), .data_o(data_o),
    .wait_o(wait_o), .unsup_o(unsup_o)
  );

  int checks = 0, errors = 0;
  // reference state
  bit m_act, m_hold, m_pol, m_early, m_pend, m_cur, m_ph, m_unsup;
  int m_addr, m_cnt, m_dq;
  bit seen_early;

  function automatic int arr_f(int a);
    return ((a & 255) << 8) | (~a & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    bit e_dv, wa, pl, e_wait;
    int e_data;
    e_dv   = m_act && !m_cur;
    wa     = m_act && (m_early ? m_pend : m_cur);
    pl     = m_act ? m_pol : pol_i;
    e_wait = pl ? wa : !wa;
    e_data = e_dv ? arr_f(m_addr) : m_dq;
    check(addr_o == AW'(m_addr), "R5 R6 R7 addr", int'(addr_o), m_addr);
    check(dvalid_o == e_dv, "R2 R8 R10 dvalid", int'(dvalid_o), int'(e_dv));
    check(data_o == DW'(e_data), "R6 data", int'(data_o), e_data);
    check(wait_o == e_wait, "R1 R3 R4 wait", int'(wait_o), int'(e_wait));
    check(unsup_o == m_unsup, "R9 unsup", int'(unsup_o), int'(m_unsup));
    if (m_early && dvalid_o && wait_o == m_pol && m_act) seen_early = 1'b1;
  endtask

  task automatic model_step();
    bit bnd;
    if (m_act && !m_cur) m_dq = arr_f(m_addr);
    if (start_i) begin
      m_act = 1; m_addr = sa_i; m_cnt = 0; m_ph = 0; m_pend = 0; m_cur = 0;
      m_hold = hold_i; m_pol = pol_i; m_early = early_i;
      if (!seq_i) m_unsup = 1;
    end else if (m_act) begin
      bnd = m_hold ? m_ph : 1'b1;
      if (bnd) begin
        if (!m_cur) begin
          m_addr = (m_addr + 1) & 255;
          m_cnt++;
          if (m_cnt == LEN) m_act = 0;
        end
        m_cur = m_pend; m_pend = stall_i; m_ph = 0;
      end else m_ph = 1;
    end
  endtask

  task automatic tick();
    #4;
    compare();
    model_step();
    @(negedge clk);
  endtask

  task automatic burst(input int sa, input bit p, input bit h, input bit e,
                       input bit s, input int smod, input int n);
    sa_i = AW'(sa); pol_i = p; hold_i = h; early_i = e; seq_i = s;
    start_i = 1; tick(); start_i = 0;
    for (int k = 0; k < n; k++) begin
      stall_i = (smod != 0) && ((k % smod) == 1);
      tick();
    end
    stall_i = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    rst_n = 0; start_i = 0; sa_i = 0; pol_i = 0; hold_i = 0; early_i = 0;
    seq_i = 1; stall_i = 0;
    m_act = 0; m_addr = 0; m_cnt = 0; m_dq = 0; m_unsup = 0; m_cur = 0; m_pend = 0;
    m_ph = 0; m_hold = 0; m_pol = 0; m_early = 0; seen_early = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(addr_o == 0 && dvalid_o == 0 && data_o == 0 && unsup_o == 0,
          "R11 reset", int'({addr_o, dvalid_o, unsup_o}), 0);
    rst_n = 1;
    @(negedge clk);
    // R4 idle level follows live polarity input
    pol_i = 1; #1;
    check(wait_o == 1'b0, "R4 idle high-pol", int'(wait_o), 0);
    pol_i = 0; #1;
    check(wait_o == 1'b1, "R4 idle low-pol", int'(wait_o), 1);
    tick();

    for (int i = 0; i < 8; i++)
      burst(16 + i * 16, i[0], i[1], i[2], 1'b1, 3 + (i % 2), 40);
    check(seen_early, "R3 early wait seen", int'(seen_early), 1);

    // R10 exact burst length
    sa_i = 8'h40; hold_i = 0; early_i = 0; start_i = 1; tick(); start_i = 0;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      if (dvalid_o) cnt++;
      tick();
    end
    check(cnt == LEN, "R10 word count", cnt, LEN);

    // R5 wrap with two-clock cycles
    burst(8'hFC, 1'b1, 1'b1, 1'b0, 1'b1, 0, 30);

    // R7 restart mid-burst
    burst(8'h20, 1'b0, 1'b1, 1'b1, 1'b1, 2, 4);
    sa_i = 8'h80; start_i = 1; tick(); start_i = 0;
    check(addr_o == 8'h80, "R7 restart addr", int'(addr_o), 8'h80);
    for (int k = 0; k < 30; k++) tick();

    // R8 cfg pins change mid-burst
    sa_i = 8'h33; pol_i = 1; hold_i = 0; early_i = 0; start_i = 1; tick(); start_i = 0;
    pol_i = 0; hold_i = 1; early_i = 1; seq_i = 0;
    tick();
    check(addr_o == 8'h34, "R8 hold unchanged", int'(addr_o), 8'h34);
    check(unsup_o == 1'b0, "R8 seq pin ignored mid-burst", int'(unsup_o), 0);
    for (int k = 0; k < 20; k++) tick();
    seq_i = 1;

    // R9 sticky unsupported ordering
    burst(8'h50, 1'b0, 1'b0, 1'b0, 1'b0, 3, 15);
    check(unsup_o == 1'b1, "R9 set", int'(unsup_o), 1);
    burst(8'h60, 1'b1, 1'b0, 1'b1, 1'b1, 0, 15);
    check(unsup_o == 1'b1, "R9 sticky", int'(unsup_o), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule